// File: doc/BRIEF.md
# Two-Way Read-Allocate Data Cache Controller

This block holds the tag, state and line storage for a 16 KB first-level data cache. The cache has two ways, 128 sets and 64-byte lines. A CPU issues single-word reads and writes through a valid/ready request port. Read hits return the word one cycle after they are accepted.

On a read miss, the block picks a victim way and requests the whole line from the lower level. It then stalls the CPU until the line arrives. The line is installed, and a dirty victim is handed to the writeback port only after the refill has landed. A refill can be flagged noncacheable. In that case the word goes to the CPU alone, nothing is installed, and the staged writeback is dropped.

Writes never allocate. A write hit updates the resident line and marks it dirty. A write miss is passed straight to a write-buffer port.

Top module: `l1d_ctrl`

## Requirements
- R1: The address is split into byte offset bits 5:0, set index bits 12:6 and tag bits 31:13. A hit needs the indexed set to hold a valid line whose tag equals bits 31:13, so an equal tag in a different set is a miss.
- R2: Two lines with the same set index and different tags can be resident together, and both hit.
- R3: An accepted read miss raises `fill_req` in the following cycle with `fill_addr` equal to the line address (offset bits zero). `fill_req` holds and `cpu_ready` stays low until `fill_valid`. In the cycle after `fill_valid`, `cpu_rvalid` is high and `cpu_rdata` carries the 32-bit word at bit position 32*addr[5:2] of `fill_data`.
- R4: An accepted write miss drives `wm_valid` with `wm_addr`/`wm_data` equal to the request in the same cycle. It allocates nothing, so a later read of that address misses. While `wm_ready` is low, a write miss is held off with `cpu_ready` low.
- R5: A write hit updates only the resident word, with no `wm_valid` and no fill. A later read returns the new word, and the line becomes dirty.
- R6: The read-miss victim is the invalid way if one exists (way 0 before way 1). Otherwise it is the way least recently read or written, where hits and installs count as uses.
- R7: When a cacheable refill replaces a valid dirty line, `wb_valid` rises in the cycle after `fill_valid` and never before it. `wb_addr` is then the victim's line address and `wb_data` its contents including all writes. The values hold until `wb_ready`.
- R8: Replacing a clean or invalid line produces no writeback.
- R9: A refill with `fill_nc` high returns the word to the CPU but installs nothing, issues no writeback and leaves the victim resident with its data.
- R10: Reset clears all valid bits. After reset `cpu_ready` is high, nothing else is asserted, and the first read misses.
- R11: An accepted read hit gives `cpu_rvalid` with the resident word in the next cycle and raises no `fill_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Request accepted this cycle when high with `cpu_valid` |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 32 | Read word |
| fill_req | output | 1 | Line refill request |
| fill_addr | output | 32 | Line address to refill |
| fill_valid | input | 1 | Refill line present |
| fill_data | input | 512 | Refill line, word n at bits 32n+31:32n |
| fill_nc | input | 1 | Refilled data is noncacheable |
| wb_valid | output | 1 | Victim writeback present |
| wb_addr | output | 32 | Victim line address |
| wb_data | output | 512 | Victim line contents |
| wb_ready | input | 1 | Writeback taken |
| wm_valid | output | 1 | Write miss to the write buffer |
| wm_addr | output | 32 | Write-miss address |
| wm_data | output | 32 | Write-miss word |
| wm_ready | input | 1 | Write buffer can take a word |

## Verification
The bench goes after the replacement order. It fills both ways of a set, touches them in a chosen order and checks which line a third tag evicts; a design with an inverted or stale LRU bit would evict the line just used.

It checks dirty tracking by writing a hit and then forcing that line out. A design that forgot the dirty bit would emit no writeback, and one that captured the line after the refill would write back the new data.

Noncacheable refills are aimed at a dirty victim. A design that still installed the line or issued the writeback would lose the victim, which shows as a later miss.

Write misses are followed by reads of the same address. A design that allocated on write would hit there, and one that ignored `wm_ready` would accept the write early.

// File: rtl/l1d_ctrl.sv
module l1d_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_valid,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic                    cpu_rvalid,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    fill_req,
  output logic [ADDR_W-1:0]       fill_addr,
  input  logic                    fill_valid,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  input  logic                    fill_nc,
  output logic                    wb_valid,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [LINE_BYTES*8-1:0] wb_data,
  input  logic                    wb_ready,
  output logic                    wm_valid,
  output logic [ADDR_W-1:0]       wm_addr,
  output logic [WORD_W-1:0]       wm_data,
  input  logic                    wm_ready
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WB} state_t;
  state_t st;

  logic [TAG_W-1:0]  tags  [2][SETS];
  logic [LINE_W-1:0] lines [2][SETS];
  logic [1:0]        vld   [SETS];
  logic [1:0]        dirty [SETS];
  logic [SETS-1:0]   lru;

  logic [TAG_W-1:0]  m_tag, m_vtag;
  logic [IDX_W-1:0]  m_idx;
  logic [WSEL_W-1:0] m_wsel;
  logic              m_way, m_wb;
  logic [LINE_W-1:0] wb_line;

  wire [IDX_W-1:0]  idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] wsel = cpu_addr[BYTE_W +: WSEL_W];
  wire unused_lsb = ^cpu_addr[BYTE_W-1:0];

  wire hit0 = vld[idx][0] && (tags[0][idx] == tag);
  wire hit1 = vld[idx][1] && (tags[1][idx] == tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire idle = (st == S_IDLE);

  wire vway   = !vld[idx][0] ? 1'b0 : (!vld[idx][1] ? 1'b1 : lru[idx]);
  wire vdirty = vld[idx][vway] && dirty[idx][vway];

  wire [LINE_W-1:0] hline = lines[hway][idx];
  wire [WORD_W-1:0] hword = hline[wsel*WORD_W +: WORD_W];
  wire [WORD_W-1:0] fword = fill_data[m_wsel*WORD_W +: WORD_W];

  assign cpu_ready = idle && (wm_ready || !cpu_we || hit);
  wire   acc       = cpu_valid && cpu_ready;

  assign wm_valid  = idle && cpu_valid && cpu_we && !hit;
  assign wm_addr   = cpu_addr;
  assign wm_data   = cpu_wdata;

  assign fill_req  = (st == S_FILL);
  assign fill_addr = {m_tag, m_idx, {OFF_W{1'b0}}};
  assign wb_valid  = (st == S_WB);
  assign wb_addr   = {m_vtag, m_idx, {OFF_W{1'b0}}};
  assign wb_data   = wb_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lru        <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      m_tag      <= '0;
      m_vtag     <= '0;
      m_idx      <= '0;
      m_wsel     <= '0;
      m_way      <= 1'b0;
      m_wb       <= 1'b0;
      for (int i = 0; i < SETS; i++) begin
        vld[i]   <= '0;
        dirty[i] <= '0;
      end
    end else begin
      cpu_rvalid <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          if (!cpu_we) begin
            if (hit) begin
              cpu_rvalid <= 1'b1;
              cpu_rdata  <= hword;
              lru[idx]   <= ~hway;
            end else begin
              m_tag  <= tag;
              m_idx  <= idx;
              m_wsel <= wsel;
              m_way  <= vway;
              m_wb   <= vdirty;
              m_vtag <= tags[vway][idx];
              st     <= S_FILL;
            end
          end else if (hit) begin
            dirty[idx][hway] <= 1'b1;
            lru[idx]         <= ~hway;
          end
        end
        S_FILL: if (fill_valid) begin
          cpu_rvalid <= 1'b1;
          cpu_rdata  <= fword;
          if (fill_nc) begin
            st <= S_IDLE;
          end else begin
            vld[m_idx][m_way]   <= 1'b1;
            dirty[m_idx][m_way] <= 1'b0;
            lru[m_idx]          <= ~m_way;
            st                  <= m_wb ? S_WB : S_IDLE;
          end
        end
        S_WB: if (wb_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (idle && acc && cpu_we && hit)
      lines[hway][idx][wsel*WORD_W +: WORD_W] <= cpu_wdata;
    if (st == S_FILL && fill_valid && !fill_nc) begin
      wb_line             <= lines[m_way][m_idx];
      lines[m_way][m_idx] <= fill_data;
      tags[m_way][m_idx]  <= m_tag;
    end
  end
endmodule

module l1d_ctrl_chk #(parameter int ADDR_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              fill_req,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              fill_valid,
  input logic              fill_nc,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              wb_ready,
  input logic              wm_valid
);
  a_r3_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr));
  a_r3_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !cpu_ready);
  a_r7_wb_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> $past(fill_req && fill_valid && !fill_nc));
  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  a_r9_nc_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_valid && fill_nc |=> !wb_valid);
  a_r4_wm_source: assert property (@(posedge clk) disable iff (!rst_n)
    wm_valid |-> cpu_valid && cpu_we && !fill_req && !wb_valid);
  a_r11_rvalid_source: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_valid && cpu_ready && !cpu_we) || $past(fill_req && fill_valid));
endmodule

bind l1d_ctrl l1d_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .fill_req(fill_req),
  .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_nc(fill_nc),
  .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
  .wm_valid(wm_valid)
);

// File: tb/l1d_ctrl_tb.sv
module l1d_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         cpu_valid = 0, cpu_we = 0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic         cpu_ready, cpu_rvalid;
  logic [31:0]  cpu_rdata;
  logic         fill_req, fill_valid = 0, fill_nc = 0;
  logic [31:0]  fill_addr;
  logic [511:0] fill_data = '0;
  logic         wb_valid, wb_ready = 0;
  logic [31:0]  wb_addr;
  logic [511:0] wb_data;
  logic         wm_valid, wm_ready = 1;
  logic [31:0]  wm_addr, wm_data;

  l1d_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .fill_req(fill_req),
    .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .fill_nc(fill_nc), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_ready(wb_ready), .wm_valid(wm_valid),
    .wm_addr(wm_addr), .wm_data(wm_data), .wm_ready(wm_ready)
  );

  int errors = 0;
  int checks = 0;

  logic [18:0] mtag   [2][128];
  bit          mval   [2][128];
  bit          mdirty [2][128];
  bit          mlru   [128];
  logic [31:0] mdat   [2][128][16];
  logic [31:0] lowmem [int unsigned];

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lower(input logic [31:0] a);
    if (lowmem.exists(a)) return lowmem[a];
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  function automatic logic [511:0] lower_line(input logic [31:0] base);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = lower(base + 32'(w * 4));
    return l;
  endfunction

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {19'(t), 7'(s), 4'(w), 2'b00};
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input bit nc, input bit wm_stall, input string rtag);
    logic [6:0]   s;
    logic [18:0]  t;
    int           w, hw, v, d;
    bit           hit, expwb;
    logic [511:0] ln, old;
    s = a[12:6]; t = a[31:13]; w = int'(a[5:2]);
    hit = 0; hw = 0;
    for (int k = 0; k < 2; k++)
      if (mval[k][s] && mtag[k][s] == t) begin hit = 1; hw = k; end
    cpu_valid = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (we && !hit && wm_stall) begin
      wm_ready = 0;
      #1;
      chk(cpu_ready == 0 && wm_valid == 1, "R4 stall", {cpu_ready, wm_valid}, 2'b01);
      cyc();
      wm_ready = 1;
    end
    #1;
    chk(cpu_ready == 1, rtag, cpu_ready, 1);
    if (we) begin
      chk(wm_valid == !hit, hit ? "R5" : "R4", wm_valid, !hit);
      if (!hit) chk(wm_addr == a && wm_data == wd, "R4", {wm_addr, wm_data}, {a, wd});
    end else begin
      chk(wm_valid == 0, "R4", wm_valid, 0);
    end
    cyc();
    cpu_valid = 0;
    #1;
    if (we) begin
      chk(fill_req == 0 && cpu_rvalid == 0, hit ? "R5" : "R4", {fill_req, cpu_rvalid}, 0);
      if (hit) begin
        mdat[hw][s][w] = wd; mdirty[hw][s] = 1; mlru[s] = ~hw[0];
      end else begin
        lowmem[a] = wd;
      end
    end else if (hit) begin
      chk(fill_req == 0, rtag, fill_req, 0);
      chk(cpu_rvalid == 1 && cpu_rdata == mdat[hw][s][w], "R11", {cpu_rvalid, cpu_rdata}, {1'b1, mdat[hw][s][w]});
      mlru[s] = ~hw[0];
    end else begin
      chk(fill_req == 1, rtag, fill_req, 1);
      chk(fill_addr == {a[31:6], 6'b0}, "R3", fill_addr, {a[31:6], 6'b0});
      v = !mval[0][s] ? 0 : (!mval[1][s] ? 1 : int'(mlru[s]));
      d = int'($urandom % 3);
      for (int k = 0; k < d; k++) begin
        cyc(); #1;
        chk(cpu_ready == 0 && fill_req == 1 && wb_valid == 0, "R3", {cpu_ready, fill_req, wb_valid}, 3'b010);
      end
      ln = lower_line({a[31:6], 6'b0});
      fill_valid = 1; fill_data = ln; fill_nc = nc;
      cyc();
      fill_valid = 0; fill_nc = 0;
      #1;
      chk(cpu_rvalid == 1 && cpu_rdata == ln[w*32 +: 32], nc ? "R9" : "R3",
          {cpu_rvalid, cpu_rdata}, {1'b1, ln[w*32 +: 32]});
      expwb = !nc && mval[v][s] && mdirty[v][s];
      chk(wb_valid == expwb, nc ? "R9" : (expwb ? "R7" : "R8"), wb_valid, expwb);
      if (expwb) begin
        for (int k = 0; k < 16; k++) old[k*32 +: 32] = mdat[v][s][k];
        chk(wb_addr == {mtag[v][s], s, 6'b0}, "R7", wb_addr, {mtag[v][s], s, 6'b0});
        chk(wb_data == old, "R7", wb_data, old);
        cyc(); #1;
        chk(wb_valid == 1, "R7", wb_valid, 1);
        wb_ready = 1;
        cyc();
        wb_ready = 0;
        for (int k = 0; k < 16; k++) lowmem[{mtag[v][s], s, 4'(k), 2'b00}] = mdat[v][s][k];
      end
      if (!nc) begin
        for (int k = 0; k < 16; k++) mdat[v][s][k] = ln[k*32 +: 32];
        mtag[v][s] = t; mval[v][s] = 1; mdirty[v][s] = 0; mlru[s] = ~v[0];
      end
      #1;
    end
    chk(cpu_ready == 1 && fill_req == 0 && wb_valid == 0, "R3", {cpu_ready, fill_req, wb_valid}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 128; s++) begin mval[k][s] = 0; mdirty[k][s] = 0; end
    for (int s = 0; s < 128; s++) mlru[s] = 0;
    repeat (3) cyc();
    #1;
    chk(cpu_ready == 1 && cpu_rvalid == 0 && fill_req == 0 && wb_valid == 0 && wm_valid == 0, "R10",
        {cpu_ready, cpu_rvalid, fill_req, wb_valid, wm_valid}, 5'b10000);
    rst_n = 1;
    cyc();

    access(0, mk(1, 5, 3), 0, 0, 0, "R10");
    access(0, mk(2, 5, 0), 0, 0, 0, "R6");
    access(0, mk(1, 5, 7), 0, 0, 0, "R2");
    access(0, mk(2, 5, 9), 0, 0, 0, "R2");
    access(0, mk(3, 5, 1), 0, 0, 0, "R6");
    access(0, mk(2, 5, 4), 0, 0, 0, "R6");
    access(0, mk(1, 6, 2), 0, 0, 0, "R1");
    access(1, mk(2, 5, 2), 32'hDEAD_BEEF, 0, 0, "R5");
    access(0, mk(2, 5, 2), 0, 0, 0, "R5");
    access(1, mk(9, 5, 6), 32'h0BAD_F00D, 0, 1, "R4");
    access(0, mk(9, 5, 6), 0, 0, 0, "R4");
    access(0, mk(4, 5, 0), 0, 0, 0, "R7");
    access(1, mk(9, 5, 1), 32'h1357_9BDF, 0, 0, "R5");
    access(0, mk(4, 5, 0), 0, 0, 0, "R11");
    access(0, mk(10, 5, 3), 0, 1, 0, "R9");
    access(0, mk(9, 5, 1), 0, 0, 0, "R9");

    for (int n = 0; n < 600; n++) begin
      int sets[4] = '{0, 5, 6, 127};
      bit we = ($urandom % 10) < 3;
      access(we, mk(int'($urandom % 4) + 1, sets[$urandom % 4], int'($urandom % 16)),
             $urandom, ($urandom % 10) == 0, ($urandom % 10) == 0, "R1");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule